// File: doc/BRIEF.md
# Upstream Address Normalizer

This block conditions every incoming transaction address before it reaches translation. A 64-bit address arrives together with four configuration codes: the width of the upstream bus, the position of the sign bit, the output-address width and the physical-address width. The block either replicates a chosen sign bit across the upper address bits, clears the bits above the bus width, or leaves the address as it is. The choice depends on the position code and, for the top position codes, on the bus-size code.

Transactions flagged as passthrough take two further steps. They are checked against the physical width, and the bits above the output width are then cut away. Any upper bit that disagrees with the extension rule raises a size-fault flag, and this flag travels with its own transaction. The datapath is combinational and ends in one output register. A valid/ready handshake on each side lets the block sit directly in a pipelined request path.

Top module: `addr_normalizer`

## Requirements
- R1: Position codes 0 to 5 select bit 31, 35, 39, 41, 43 or 47 as the sign bit, and every higher output bit equals that bit.
- R2: Position code 6 gives results identical to position code 7 for the same address and bus code.
- R3: With position code 6 or 7 and bus code 4'b1111 (64 bits), the address leaves unchanged with no fault. The unused bus codes 4'b0110 to 4'b1110 are handled the same way.
- R4: With position code 6 or 7 and bus code 4'b0101 (49 bits), bit 48 is copied into bits 63:49.
- R5: With position code 6 or 7 and bus code 0, 1, 2, 3 or 4 (32, 36, 40, 42 or 44 bits), all bits at and above that width are cleared.
- R6: The size fault is raised when an input bit above the sign bit differs from the sign bit. When zero-filling, it is raised when an input bit at or above the bus width is set.
- R7: For passthrough transactions (bypass_i=1), output bits at and above the output width are cleared. Output-width codes 0 to 5 mean 32, 36, 40, 42, 44 and 48 bits; codes 6 and 7 mean 48 bits.
- R8: For passthrough transactions, the size fault is also raised when the extended address has any bit set at or above the physical width. The physical width uses the same code table as R7.
- R9: For translated transactions (bypass_i=0), the output- and physical-width codes have no effect on the address or the fault.
- R10: in_ready_o is high exactly when out_valid_o is low or out_ready_i is high. The output register loads only on an accepted input. While out_valid_o is high and out_ready_i is low, the output holds steady.
- R11: After reset, out_valid_o is low and in_ready_o is high.
- R12: Each result appears in acceptance order with its own fault flag, including under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input transaction valid |
| in_ready_o | output | 1 | Block can accept an input |
| addr_i | input | 64 | Upstream address |
| bus_code_i | input | 4 | Upstream bus width code |
| sep_code_i | input | 3 | Sign bit position code |
| oas_code_i | input | 3 | Output address width code |
| pa_code_i | input | 3 | Physical address width code |
| bypass_i | input | 1 | Transaction is passthrough |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts result |
| addr_o | output | 64 | Normalized address |
| size_fault_o | output | 1 | Address size fault for this result |

## Verification
The bench targets the deferred position codes. A design that decoded code 6 as its own case, or that ignored the bus code under code 7, would sign-extend where it should zero-fill or leave the address alone. Each sign position is tried with a positive address, a negative address and a mixed upper field. An off-by-one in the bit comparison would then either smear the sign into a data bit or miss a fault. Passthrough vectors use reserved width codes and addresses that straddle the physical and output widths, which exposes a truncation done before the physical check or a reserved code that is not mapped to 48 bits. A periodic stall on the output side catches results that are overwritten, duplicated or carry a neighbour's fault flag.

// File: rtl/addr_norm_pkg.sv
package addr_norm_pkg;
  parameter int unsigned ADDR_W = 64;
  localparam int unsigned IDX_W = $clog2(ADDR_W);
  localparam int unsigned WID_W = IDX_W + 1;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0,
    EXT_SIGN = 2'd1,
    EXT_ZERO = 2'd2
  } ext_mode_e;

  // unused bus codes fall back to full width
  function automatic logic [WID_W-1:0] bus_width(input logic [3:0] code);
    case (code)
      4'd0:    return WID_W'(32);
      4'd1:    return WID_W'(36);
      4'd2:    return WID_W'(40);
      4'd3:    return WID_W'(42);
      4'd4:    return WID_W'(44);
      4'd5:    return WID_W'(49);
      default: return WID_W'(ADDR_W);
    endcase
  endfunction

  // reserved width codes behave as 48 bits
  function automatic logic [WID_W-1:0] size_width(input logic [2:0] code);
    case (code)
      3'd0:    return WID_W'(32);
      3'd1:    return WID_W'(36);
      3'd2:    return WID_W'(40);
      3'd3:    return WID_W'(42);
      3'd4:    return WID_W'(44);
      default: return WID_W'(48);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] sign_pos(input logic [2:0] code);
    case (code)
      3'd0:    return IDX_W'(31);
      3'd1:    return IDX_W'(35);
      3'd2:    return IDX_W'(39);
      3'd3:    return IDX_W'(41);
      3'd4:    return IDX_W'(43);
      default: return IDX_W'(47);
    endcase
  endfunction
endpackage

// File: rtl/addr_norm_ext_decode.sv
module addr_norm_ext_decode
  import addr_norm_pkg::*;
(
  input  logic [2:0]       sep_code_i,
  input  logic [3:0]       bus_code_i,
  output ext_mode_e        mode_o,
  output logic [IDX_W-1:0] keep_bit_o
);
  always_comb begin
    mode_o     = EXT_NONE;
    keep_bit_o = IDX_W'(ADDR_W - 1);
    if (sep_code_i[2:1] != 2'b11) begin
      mode_o     = EXT_SIGN;
      keep_bit_o = sign_pos(sep_code_i);
    end else begin
      // top position codes defer to the bus width
      case (bus_code_i)
        4'd5: begin
          mode_o     = EXT_SIGN;
          keep_bit_o = IDX_W'(48);
        end
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4: begin
          mode_o     = EXT_ZERO;
          keep_bit_o = IDX_W'(bus_width(bus_code_i) - 1);
        end
        default: begin
          mode_o     = EXT_NONE;
          keep_bit_o = IDX_W'(ADDR_W - 1);
        end
      endcase
    end
  end
endmodule

// File: rtl/addr_norm_extend.sv
module addr_norm_extend
  import addr_norm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned IW = $clog2(AW)
) (
  input  logic [AW-1:0] addr_i,
  input  ext_mode_e     mode_i,
  input  logic [IW-1:0] keep_bit_i,
  output logic [AW-1:0] addr_o,
  output logic          fault_o
);
  logic          fill;
  logic          active;
  logic [AW-1:0] above;

  assign active = (mode_i != EXT_NONE);
  assign fill   = (mode_i == EXT_SIGN) ? addr_i[keep_bit_i] : 1'b0;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign above[i]  = IW'(i) > keep_bit_i;
    assign addr_o[i] = (active && above[i]) ? fill : addr_i[i];
  end

  assign fault_o = active && (|((addr_i ^ {AW{fill}}) & above));
endmodule

// File: rtl/addr_norm_limit.sv
module addr_norm_limit
  import addr_norm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          bypass_i,
  input  logic [2:0]    oas_code_i,
  input  logic [2:0]    pa_code_i,
  output logic [AW-1:0] addr_o,
  output logic          fault_o
);
  logic [WID_W-1:0] out_w;
  logic [WID_W-1:0] pa_w;
  logic [AW-1:0]    out_keep;
  logic [AW-1:0]    pa_over;

  assign out_w = size_width(oas_code_i);
  assign pa_w  = size_width(pa_code_i);

  for (genvar i = 0; i < AW; i++) begin : g_mask
    assign out_keep[i] = WID_W'(i) < out_w;
    assign pa_over[i]  = WID_W'(i) >= pa_w;
  end

  // physical check sees the address before truncation
  assign fault_o = bypass_i && (|(addr_i & pa_over));
  assign addr_o  = bypass_i ? (addr_i & out_keep) : addr_i;
endmodule

// File: rtl/addr_normalizer.sv
module addr_normalizer
  import addr_norm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [63:0]   addr_i,
  input  logic [3:0]    bus_code_i,
  input  logic [2:0]    sep_code_i,
  input  logic [2:0]    oas_code_i,
  input  logic [2:0]    pa_code_i,
  input  logic          bypass_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [63:0]   addr_o,
  output logic          size_fault_o
);
  ext_mode_e        mode;
  logic [IDX_W-1:0] keep_bit;
  logic [63:0]      ext_addr;
  logic             ext_fault;
  logic [63:0]      lim_addr;
  logic             lim_fault;

  logic             valid_q;
  logic [63:0]      addr_q;
  logic             fault_q;

  addr_norm_ext_decode u_decode (
    .sep_code_i (sep_code_i),
    .bus_code_i (bus_code_i),
    .mode_o     (mode),
    .keep_bit_o (keep_bit)
  );

  addr_norm_extend #(.AW(64)) u_extend (
    .addr_i     (addr_i),
    .mode_i     (mode),
    .keep_bit_i (keep_bit),
    .addr_o     (ext_addr),
    .fault_o    (ext_fault)
  );

  addr_norm_limit #(.AW(64)) u_limit (
    .addr_i     (ext_addr),
    .bypass_i   (bypass_i),
    .oas_code_i (oas_code_i),
    .pa_code_i  (pa_code_i),
    .addr_o     (lim_addr),
    .fault_o    (lim_fault)
  );

  assign in_ready_o = !valid_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      if (in_ready_o) valid_q <= in_valid_i;
      if (in_valid_i && in_ready_o) begin
        addr_q  <= lim_addr;
        fault_q <= ext_fault | lim_fault;
      end
    end
  end

  assign out_valid_o  = valid_q;
  assign addr_o       = addr_q;
  assign size_fault_o = fault_q;
endmodule

// File: rtl/addr_normalizer_chk.sv
module addr_normalizer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [63:0] addr_i,
  input logic [3:0]  bus_code_i,
  input logic [2:0]  sep_code_i,
  input logic [2:0]  oas_code_i,
  input logic [2:0]  pa_code_i,
  input logic        bypass_i,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [63:0] addr_o,
  input logic        size_fault_o
);
  logic accept;
  logic top_code;
  assign accept   = in_valid_i && in_ready_o;
  assign top_code = (sep_code_i[2:1] == 2'b11);

  a_r10_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(addr_o) && $stable(size_fault_o));

  a_r10_load_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  a_r10_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o);

  a_r3_full_bus_unchanged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && top_code && bus_code_i == 4'hF && !bypass_i
      |=> addr_o == $past(addr_i) && !size_fault_o);

  a_r4_bit48_copied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && top_code && bus_code_i == 4'h5 && !bypass_i
      |=> addr_o[63:49] == {15{addr_o[48]}});

  a_r5_zero_fill_32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && top_code && bus_code_i == 4'h0 && !bypass_i |=> addr_o[63:32] == 32'd0);

  a_r7_trunc_32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && bypass_i && oas_code_i == 3'd0 |=> addr_o[63:32] == 32'd0);
endmodule

bind addr_normalizer addr_normalizer_chk u_chk (.*);

// File: tb/addr_normalizer_tb.sv
`timescale 1ns/1ps
module addr_normalizer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] addr_in = '0;
  logic [3:0]  bus_code = '0;
  logic [2:0]  sep_code = '0;
  logic [2:0]  oas_code = '0;
  logic [2:0]  pa_code = '0;
  logic        bypass = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] addr_out;
  logic        fault_out;

  typedef struct {
    logic [63:0] a;
    logic        f;
    string       tag;
  } item_t;
  item_t sb_q[$];

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done = 0;
  bit  stall_mode = 0;
  int  cyc = 0;

  always #2 clk = ~clk;

  addr_normalizer u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .addr_i(addr_in), .bus_code_i(bus_code), .sep_code_i(sep_code),
    .oas_code_i(oas_code), .pa_code_i(pa_code), .bypass_i(bypass),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .addr_o(addr_out), .size_fault_o(fault_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] c);
    int w;
    case (c)
      3'd0: w = 32; 3'd1: w = 36; 3'd2: w = 40;
      3'd3: w = 42; 3'd4: w = 44; default: w = 48;
    endcase
    return w;
  endfunction

  function automatic void model(input logic [63:0] a, input logic [3:0] bus,
      input logic [2:0] sep, input logic [2:0] oas, input logic [2:0] pa,
      input logic byp, output logic [63:0] r, output logic f);
    int sbit = 63;
    int mode = 0; // 0 keep, 1 sign, 2 zero
    logic fill;
    r = a;
    f = 1'b0;
    case (sep)
      3'd0: begin mode = 1; sbit = 31; end
      3'd1: begin mode = 1; sbit = 35; end
      3'd2: begin mode = 1; sbit = 39; end
      3'd3: begin mode = 1; sbit = 41; end
      3'd4: begin mode = 1; sbit = 43; end
      3'd5: begin mode = 1; sbit = 47; end
      default: begin
        case (bus)
          4'd5: begin mode = 1; sbit = 48; end
          4'd0: begin mode = 2; sbit = 31; end
          4'd1: begin mode = 2; sbit = 35; end
          4'd2: begin mode = 2; sbit = 39; end
          4'd3: begin mode = 2; sbit = 41; end
          4'd4: begin mode = 2; sbit = 43; end
          default: mode = 0;
        endcase
      end
    endcase
    if (mode != 0) begin
      fill = (mode == 1) ? a[sbit] : 1'b0;
      for (int i = sbit + 1; i < 64; i++) begin
        if (a[i] != fill) f = 1'b1;
        r[i] = fill;
      end
    end
    if (byp) begin
      for (int i = width_of(pa); i < 64; i++) if (r[i]) f = 1'b1;
      for (int i = width_of(oas); i < 64; i++) r[i] = 1'b0;
    end
  endfunction

  task automatic send(input logic [63:0] a, input logic [3:0] bus, input logic [2:0] sep,
                      input logic [2:0] oas, input logic [2:0] pa, input logic byp,
                      input string tag);
    item_t it;
    @(negedge clk);
    addr_in = a; bus_code = bus; sep_code = sep;
    oas_code = oas; pa_code = pa; bypass = byp; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    model(a, bus, sep, oas, pa, byp, it.a, it.f);
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // output-side back-pressure
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit          stalled = 0;
    logic [63:0] prev_a = '0;
    logic        prev_f = 1'b0;
    item_t       it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (stalled)
          chk(out_valid && addr_out == prev_a && fault_out == prev_f, "R10",
              "hold under stall", addr_out, prev_a);
        chk(in_ready == (!out_valid || out_ready), "R10", "ready rule",
            64'(in_ready), 64'(!out_valid || out_ready));
        if (out_valid && out_ready) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected result", addr_out, '0);
          end else begin
            it = sb_q.pop_front();
            chk(addr_out == it.a, it.tag, "address", addr_out, it.a);
            chk(fault_out == it.f, it.tag, "size fault", 64'(fault_out), 64'(it.f));
          end
        end
        stalled = out_valid && !out_ready;
        prev_a  = addr_out;
        prev_f  = fault_out;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fails++;
      $display("FAIL R10 watchdog expired: actual hung expected drained");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11", "valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R11", "ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11", "valid after reset", 64'(out_valid), 64'd0);

    // R1 / R6: fixed sign positions
    send(64'h0000_0000_8000_1234, 4'hF, 3'd0, 3'd0, 3'd0, 1'b0, "R1");
    send(64'hFFFF_FFFF_8000_1234, 4'hF, 3'd0, 3'd0, 3'd0, 1'b0, "R1");
    send(64'h0000_0008_0000_0000, 4'hF, 3'd1, 3'd0, 3'd0, 1'b0, "R1");
    send(64'hFFFF_FF80_0000_0001, 4'hF, 3'd2, 3'd0, 3'd0, 1'b0, "R1");
    send(64'h0000_0200_0000_0000, 4'h0, 3'd3, 3'd0, 3'd0, 1'b0, "R1");
    send(64'h0000_0800_0000_0000, 4'h0, 3'd4, 3'd0, 3'd0, 1'b0, "R1");
    send(64'h0000_7FFF_0000_0000, 4'hF, 3'd5, 3'd0, 3'd0, 1'b0, "R1");
    send(64'h0000_8000_0000_0000, 4'hF, 3'd5, 3'd0, 3'd0, 1'b0, "R1");
    send(64'hFFFF_FFFE_8000_0000, 4'hF, 3'd0, 3'd0, 3'd0, 1'b0, "R6");
    send(64'hFFFF_F000_0000_0000, 4'hF, 3'd4, 3'd0, 3'd0, 1'b0, "R6");
    send(64'h0000_0000_7FFF_FFFF, 4'hF, 3'd0, 3'd0, 3'd0, 1'b0, "R6");

    // R2: code 6 mirrors code 7
    send(64'h0001_0000_0000_0000, 4'h5, 3'd6, 3'd0, 3'd0, 1'b0, "R2");
    send(64'h0001_0000_0000_0000, 4'h5, 3'd7, 3'd0, 3'd0, 1'b0, "R2");
    send(64'h0000_0001_2345_6789, 4'h0, 3'd6, 3'd0, 3'd0, 1'b0, "R2");
    send(64'hDEAD_BEEF_0123_4567, 4'hF, 3'd6, 3'd0, 3'd0, 1'b0, "R2");

    // R3: full or unused bus codes
    send(64'hDEAD_BEEF_0123_4567, 4'hF, 3'd7, 3'd0, 3'd0, 1'b0, "R3");
    send(64'hDEAD_BEEF_0123_4567, 4'h8, 3'd7, 3'd0, 3'd0, 1'b0, "R3");
    send(64'h8000_0000_0000_0001, 4'hE, 3'd7, 3'd0, 3'd0, 1'b0, "R3");

    // R4: 49-bit bus
    send(64'h0001_2345_6789_ABCD, 4'h5, 3'd7, 3'd0, 3'd0, 1'b0, "R4");
    send(64'hFFFF_1234_5678_9ABC, 4'h5, 3'd7, 3'd0, 3'd0, 1'b0, "R4");
    send(64'h0000_FFFF_FFFF_FFFF, 4'h5, 3'd7, 3'd0, 3'd0, 1'b0, "R4");

    // R5: zero fill
    send(64'h0000_0001_2345_6789, 4'h0, 3'd7, 3'd0, 3'd0, 1'b0, "R5");
    send(64'h0000_0010_2345_6789, 4'h1, 3'd7, 3'd0, 3'd0, 1'b0, "R5");
    send(64'hFFFF_FFFF_FFFF_FFFF, 4'h2, 3'd7, 3'd0, 3'd0, 1'b0, "R5");
    send(64'h0000_03FF_FFFF_FFFF, 4'h3, 3'd7, 3'd0, 3'd0, 1'b0, "R5");
    send(64'h0000_0FFF_FFFF_FFFF, 4'h4, 3'd7, 3'd0, 3'd0, 1'b0, "R5");

    // R7: passthrough truncation
    send(64'h0000_00AB_CDEF_1234, 4'hF, 3'd7, 3'd0, 3'd7, 1'b1, "R7");
    send(64'h0000_00AB_CDEF_1234, 4'hF, 3'd7, 3'd1, 3'd7, 1'b1, "R7");
    send(64'h0000_FFFF_FFFF_FFFF, 4'hF, 3'd7, 3'd3, 3'd7, 1'b1, "R7");
    send(64'h0000_FFFF_FFFF_FFFF, 4'hF, 3'd7, 3'd5, 3'd7, 1'b1, "R7");
    send(64'h0000_FFFF_FFFF_FFFF, 4'hF, 3'd7, 3'd6, 3'd7, 1'b1, "R7");

    // R8: physical width check
    send(64'h0000_0001_0000_0000, 4'hF, 3'd7, 3'd7, 3'd0, 1'b1, "R8");
    send(64'h0000_0FFF_FFFF_FFFF, 4'hF, 3'd7, 3'd7, 3'd4, 1'b1, "R8");
    send(64'h0001_0000_0000_0000, 4'hF, 3'd7, 3'd0, 3'd7, 1'b1, "R8");
    send(64'hFFFF_FFFF_8000_0000, 4'hF, 3'd0, 3'd5, 3'd5, 1'b1, "R8");

    // R9: width codes ignored when translated
    send(64'h00FF_0000_0000_0000, 4'hF, 3'd7, 3'd0, 3'd0, 1'b0, "R9");
    send(64'h0000_0123_4567_89AB, 4'h4, 3'd7, 3'd0, 3'd0, 1'b0, "R9");

    // R10 / R12: back-pressure with interleaved faults
    stall_mode = 1;
    for (int k = 0; k < 24; k++) begin
      if (k % 2 == 0)
        send(64'h0000_0000_8000_0000 | 64'(k), 4'hF, 3'd0, 3'd0, 3'd0, 1'b0, "R12");
      else
        send(64'hFFFF_FFFF_8000_0000 | 64'(k), 4'hF, 3'd0, 3'd0, 3'd0, 1'b0, "R12");
    end
    idle();
    repeat (20) @(posedge clk);
    stall_mode = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1;
    chk(sb_q.size() == 0, "R12", "results drained", 64'(sb_q.size()), 64'd0);
    chk(out_valid == 1'b0, "R10", "valid drops when idle", 64'(out_valid), 64'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule